// File: doc/BRIEF.md
# Branch and Skip Resolver

This block resolves the control-flow outcome of one instruction per clock. It receives the current program counter, the instruction's class, its relative offset, the status byte, a flag index, a bit index, a test byte, two register operands for equality skips, the 16-bit indirect pointer and a flag that marks the following instruction as two words long. From these it produces the next program counter, a taken indication and the number of cycles that the instruction occupies.

A sequencer presents one decoded instruction with `in_valid` high. One clock later the registered result appears with `out_valid` high. Conditional branches test one status flag, or the signed relation formed from the negative and overflow flags. Skips test one bit of a byte or compare two registers, and they step over one or two words. Relative jumps and calls, and indirect jumps and calls, are always taken. Stack traffic and the fetch of two-word instructions are handled elsewhere.

Top module: `branch_resolve`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first valid instruction, `out_valid`, `npc`, `taken` and `cycles` are all zero.
- R2: Opcode 1 is taken when `sreg[flag_sel]` is 1, and opcode 2 is taken when it is 0. The status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. When taken, `npc` = pc + sign-extended `offset[6:0]` + 1. When not taken, `npc` = pc + 1.
- R3: A conditional branch (opcodes 1 to 4) reports 1 cycle and `taken`=0 when its condition is false. It reports 2 cycles and `taken`=1 when its condition is true.
- R4: Opcode 3 (signed greater-or-equal) is taken when N XOR V = 0. Opcode 4 (signed less-than) is taken when N XOR V = 1. The S bit (bit 4) has no effect on either.
- R5: Opcode 5 (relative jump) and opcode 6 (relative call) set `npc` = pc + sign-extended 12-bit `offset` + 1 and set `taken`=1. The jump reports 2 cycles and the call reports 3.
- R6: Opcode 7 (indirect jump) and opcode 8 (indirect call) set `npc` = `zptr` and set `taken`=1. The jump reports 2 cycles and the call reports 3.
- R7: Opcode 9 skips when `test_byte[bit_idx]` is 0, and opcode 10 skips when that bit is 1. A skip sets `npc` = pc + 2 and 2 cycles when `next_two_word`=0, and `npc` = pc + 3 and 3 cycles when `next_two_word`=1, with `taken`=1. With no skip, `npc` = pc + 1, 1 cycle and `taken`=0.
- R8: Opcode 11 skips, with the same rules as R7, when `rd_val` equals `rr_val`.
- R9: The result of an instruction accepted at one clock edge appears at the next edge, with `out_valid`=1. A cycle with `in_valid`=0 clears `out_valid` and leaves `npc`, `taken` and `cycles` unchanged, whatever the other inputs do.
- R10: Opcodes 0 and 12 to 15 give `npc` = pc + 1, `taken`=0 and 1 cycle.
- R11: All next-PC arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| op | input | 4 | Instruction class code (see requirements) |
| pc | input | 16 | Address of the current instruction |
| offset | input | 12 | Signed relative offset; branches use bits 6:0 |
| sreg | input | 8 | Status byte |
| flag_sel | input | 3 | Status bit tested by opcodes 1 and 2 |
| bit_idx | input | 3 | Bit of `test_byte` tested by bit skips |
| test_byte | input | 8 | Register or I/O byte for bit skips |
| rd_val | input | 8 | First operand of the equality skip |
| rr_val | input | 8 | Second operand of the equality skip |
| zptr | input | 16 | Indirect jump or call target |
| next_two_word | input | 1 | The following instruction is two words long |
| out_valid | output | 1 | Result registered this cycle |
| npc | output | 16 | Next program counter |
| taken | output | 1 | Control flow left the sequential path |
| cycles | output | 2 | Cycles consumed by the instruction |

## Verification
Two functions can fall in the same cycle here: the condition test and the choice of step size in a skip. A skip whose condition holds while `next_two_word` is set must produce the three-word step and three cycles together. A false condition with the same flag set must fall back to a one-word step and ignore the flag. The random stimulus draws the condition inputs and the length flag independently, so every combination of the two occurs. Directed cases pin the two-word skip, the false skip with the flag set, the extreme branch offsets and the wrap at the top of the address space. Each result is compared in full (next PC, taken and cycles) against a model built from the requirements.

// File: rtl/brres_pkg.sv
package brres_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_BRSET = 4'd1,
        OP_BRCLR = 4'd2,
        OP_BRSGE = 4'd3,
        OP_BRSLT = 4'd4,
        OP_RJMP  = 4'd5,
        OP_RCALL = 4'd6,
        OP_IJMP  = 4'd7,
        OP_ICALL = 4'd8,
        OP_SKBC  = 4'd9,
        OP_SKBS  = 4'd10,
        OP_SKEQ  = 4'd11
    } brres_op_e;

    typedef enum logic [1:0] {
        PATH_STEP = 2'd0,
        PATH_REL  = 2'd1,
        PATH_ABS  = 2'd2,
        PATH_SKIP = 2'd3
    } brres_path_e;

    localparam int FLAG_N_POS = 2;
    localparam int FLAG_V_POS = 3;
    localparam int CYC_W      = 2;

endpackage

// File: rtl/brres_cond.sv
module brres_cond
    import brres_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  brres_op_e          op_i,
    input  logic [DATA_W-1:0]  sreg_i,
    input  logic [SEL_W-1:0]   flag_sel_i,
    input  logic [SEL_W-1:0]   bit_idx_i,
    input  logic [DATA_W-1:0]  test_byte_i,
    input  logic [DATA_W-1:0]  rd_val_i,
    input  logic [DATA_W-1:0]  rr_val_i,
    output logic               hit_o
);

    logic sel_flag;
    logic sel_bit;
    logic signed_lt;

    always_comb begin
        sel_flag  = sreg_i[flag_sel_i];
        sel_bit   = test_byte_i[bit_idx_i];
        signed_lt = sreg_i[FLAG_N_POS] ^ sreg_i[FLAG_V_POS];
        unique case (op_i)
            OP_BRSET: hit_o = sel_flag;
            OP_BRCLR: hit_o = ~sel_flag;
            OP_BRSGE: hit_o = ~signed_lt;
            OP_BRSLT: hit_o = signed_lt;
            OP_SKBC:  hit_o = ~sel_bit;
            OP_SKBS:  hit_o = sel_bit;
            OP_SKEQ:  hit_o = (rd_val_i == rr_val_i);
            default:  hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/brres_timing.sv
module brres_timing
    import brres_pkg::*;
(
    input  brres_op_e         op_i,
    input  logic              hit_i,
    input  logic              two_word_i,
    output logic              taken_o,
    output logic [CYC_W-1:0]  cycles_o,
    output brres_path_e       path_o,
    output logic              short_off_o
);

    always_comb begin
        taken_o     = 1'b0;
        cycles_o    = CYC_W'(1);
        path_o      = PATH_STEP;
        short_off_o = 1'b0;
        unique case (op_i)
            OP_BRSET, OP_BRCLR, OP_BRSGE, OP_BRSLT: begin
                short_off_o = 1'b1;
                if (hit_i) begin
                    taken_o  = 1'b1;
                    cycles_o = CYC_W'(2);
                    path_o   = PATH_REL;
                end
            end
            OP_RJMP: begin
                taken_o  = 1'b1;
                cycles_o = CYC_W'(2);
                path_o   = PATH_REL;
            end
            OP_RCALL: begin
                taken_o  = 1'b1;
                cycles_o = CYC_W'(3);
                path_o   = PATH_REL;
            end
            OP_IJMP: begin
                taken_o  = 1'b1;
                cycles_o = CYC_W'(2);
                path_o   = PATH_ABS;
            end
            OP_ICALL: begin
                taken_o  = 1'b1;
                cycles_o = CYC_W'(3);
                path_o   = PATH_ABS;
            end
            OP_SKBC, OP_SKBS, OP_SKEQ: begin
                if (hit_i) begin
                    taken_o  = 1'b1;
                    cycles_o = two_word_i ? CYC_W'(3) : CYC_W'(2);
                    path_o   = PATH_SKIP;
                end
            end
            default: begin
                taken_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/brres_target.sv
module brres_target #(
    parameter int PC_W    = 16,
    parameter int BR_K_W  = 7,
    parameter int JMP_K_W = 12
) (
    input  logic [PC_W-1:0]    pc_i,
    input  logic [JMP_K_W-1:0] k_i,
    input  logic               short_off_i,
    input  logic               two_word_i,
    output logic [PC_W-1:0]    pc_seq_o,
    output logic [PC_W-1:0]    pc_rel_o,
    output logic [PC_W-1:0]    pc_skip_o
);

    logic [PC_W-1:0] off_short;
    logic [PC_W-1:0] off_long;
    logic [PC_W-1:0] off_sel;

    generate
        if (PC_W > BR_K_W) begin : g_short_ext
            assign off_short = {{(PC_W-BR_K_W){k_i[BR_K_W-1]}}, k_i[BR_K_W-1:0]};
        end else begin : g_short_cut
            assign off_short = k_i[PC_W-1:0];
        end
        if (PC_W > JMP_K_W) begin : g_long_ext
            assign off_long = {{(PC_W-JMP_K_W){k_i[JMP_K_W-1]}}, k_i};
        end else begin : g_long_cut
            assign off_long = k_i[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        off_sel   = short_off_i ? off_short : off_long;
        pc_seq_o  = pc_i + PC_W'(1);
        pc_rel_o  = pc_i + off_sel + PC_W'(1);
        pc_skip_o = pc_i + (two_word_i ? PC_W'(3) : PC_W'(2));
    end

endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
    import brres_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int DATA_W  = 8,
    parameter int BR_K_W  = 7,
    parameter int JMP_K_W = 12,
    localparam int SEL_W  = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [3:0]         op,
    input  logic [PC_W-1:0]    pc,
    input  logic [JMP_K_W-1:0] offset,
    input  logic [DATA_W-1:0]  sreg,
    input  logic [SEL_W-1:0]   flag_sel,
    input  logic [SEL_W-1:0]   bit_idx,
    input  logic [DATA_W-1:0]  test_byte,
    input  logic [DATA_W-1:0]  rd_val,
    input  logic [DATA_W-1:0]  rr_val,
    input  logic [PC_W-1:0]    zptr,
    input  logic               next_two_word,
    output logic               out_valid,
    output logic [PC_W-1:0]    npc,
    output logic               taken,
    output logic [CYC_W-1:0]   cycles
);

    typedef struct packed {
        logic              vld;
        logic [PC_W-1:0]   npc;
        logic              tkn;
        logic [CYC_W-1:0]  cyc;
    } res_t;

    brres_op_e        op_e;
    logic             cond_hit;
    logic             tkn_c;
    logic [CYC_W-1:0] cyc_c;
    brres_path_e      path_c;
    logic             short_c;
    logic [PC_W-1:0]  pc_seq;
    logic [PC_W-1:0]  pc_rel;
    logic [PC_W-1:0]  pc_skip;
    res_t             res_d;
    res_t             res_q;

    assign op_e = brres_op_e'(op);

    brres_cond #(.DATA_W(DATA_W)) u_cond (
        .op_i        (op_e),
        .sreg_i      (sreg),
        .flag_sel_i  (flag_sel),
        .bit_idx_i   (bit_idx),
        .test_byte_i (test_byte),
        .rd_val_i    (rd_val),
        .rr_val_i    (rr_val),
        .hit_o       (cond_hit)
    );

    brres_timing u_timing (
        .op_i        (op_e),
        .hit_i       (cond_hit),
        .two_word_i  (next_two_word),
        .taken_o     (tkn_c),
        .cycles_o    (cyc_c),
        .path_o      (path_c),
        .short_off_o (short_c)
    );

    brres_target #(
        .PC_W    (PC_W),
        .BR_K_W  (BR_K_W),
        .JMP_K_W (JMP_K_W)
    ) u_target (
        .pc_i        (pc),
        .k_i         (offset),
        .short_off_i (short_c),
        .two_word_i  (next_two_word),
        .pc_seq_o    (pc_seq),
        .pc_rel_o    (pc_rel),
        .pc_skip_o   (pc_skip)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = 1'b0;
        if (in_valid) begin
            res_d.vld = 1'b1;
            res_d.tkn = tkn_c;
            res_d.cyc = cyc_c;
            unique case (path_c)
                PATH_REL:  res_d.npc = pc_rel;
                PATH_ABS:  res_d.npc = zptr;
                PATH_SKIP: res_d.npc = pc_skip;
                default:   res_d.npc = pc_seq;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.vld;
    assign npc       = res_q.npc;
    assign taken     = res_q.tkn;
    assign cycles    = res_q.cyc;

    // R9
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(npc) && $stable(taken) && $stable(cycles)));

    // R3
    untaken_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken) |-> (cycles == CYC_W'(1)));

    // R5
    taken_multi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && taken) |-> (cycles >= CYC_W'(2)));

    // R10
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken) |-> (npc == PC_W'($past(pc) + PC_W'(1))));

    // R6
    indirect_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 4'd7 || op == 4'd8)) |=> (npc == $past(zptr)));

endmodule

// File: tb/tb_branch_resolve.sv
module tb_branch_resolve;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [15:0] pc = '0;
    logic [11:0] offset = '0;
    logic [7:0]  sreg = '0;
    logic [2:0]  flag_sel = '0;
    logic [2:0]  bit_idx = '0;
    logic [7:0]  test_byte = '0;
    logic [7:0]  rd_val = '0;
    logic [7:0]  rr_val = '0;
    logic [15:0] zptr = '0;
    logic        next_two_word = 1'b0;
    logic        out_valid;
    logic [15:0] npc;
    logic        taken;
    logic [1:0]  cycles;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] last_npc = '0;
    logic        last_tkn = 1'b0;
    logic [1:0]  last_cyc = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_resolve dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .pc(pc),
        .offset(offset), .sreg(sreg), .flag_sel(flag_sel), .bit_idx(bit_idx),
        .test_byte(test_byte), .rd_val(rd_val), .rr_val(rr_val), .zptr(zptr),
        .next_two_word(next_two_word), .out_valid(out_valid), .npc(npc),
        .taken(taken), .cycles(cycles)
    );

    function automatic void model(
        input  logic [3:0]  m_op,
        input  logic [15:0] m_pc,
        input  logic [11:0] m_k,
        input  logic [7:0]  m_sreg,
        input  logic [2:0]  m_fs,
        input  logic [2:0]  m_bi,
        input  logic [7:0]  m_tb,
        input  logic [7:0]  m_rd,
        input  logic [7:0]  m_rr,
        input  logic [15:0] m_z,
        input  logic        m_two,
        output logic [15:0] e_npc,
        output logic        e_tkn,
        output logic [1:0]  e_cyc,
        output string       tag
    );
        logic [15:0] s7;
        logic [15:0] s12;
        logic        c;
        s7  = {{9{m_k[6]}}, m_k[6:0]};
        s12 = {{4{m_k[11]}}, m_k};
        e_npc = m_pc + 16'd1;
        e_tkn = 1'b0;
        e_cyc = 2'd1;
        c     = 1'b0;
        case (m_op)
            4'd1, 4'd2, 4'd3, 4'd4: begin
                tag = (m_op <= 4'd2) ? "R2/R3" : "R4/R3";
                case (m_op)
                    4'd1:    c = m_sreg[m_fs];
                    4'd2:    c = !m_sreg[m_fs];
                    4'd3:    c = (m_sreg[2] == m_sreg[3]);
                    default: c = (m_sreg[2] != m_sreg[3]);
                endcase
                if (c) begin
                    e_npc = m_pc + s7 + 16'd1;
                    e_tkn = 1'b1;
                    e_cyc = 2'd2;
                end
            end
            4'd5, 4'd6: begin
                tag = "R5";
                e_npc = m_pc + s12 + 16'd1;
                e_tkn = 1'b1;
                e_cyc = (m_op == 4'd5) ? 2'd2 : 2'd3;
            end
            4'd7, 4'd8: begin
                tag = "R6";
                e_npc = m_z;
                e_tkn = 1'b1;
                e_cyc = (m_op == 4'd7) ? 2'd2 : 2'd3;
            end
            4'd9, 4'd10, 4'd11: begin
                tag = (m_op == 4'd11) ? "R8" : "R7";
                case (m_op)
                    4'd9:    c = !m_tb[m_bi];
                    4'd10:   c = m_tb[m_bi];
                    default: c = (m_rd == m_rr);
                endcase
                if (c) begin
                    e_npc = m_pc + (m_two ? 16'd3 : 16'd2);
                    e_tkn = 1'b1;
                    e_cyc = m_two ? 2'd3 : 2'd2;
                end
            end
            default: tag = "R10";
        endcase
    endfunction

    task automatic check_out(input string tag, input logic [15:0] e_npc,
                             input logic e_tkn, input logic [1:0] e_cyc, input logic e_vld);
        checks++;
        if (out_valid !== e_vld || npc !== e_npc || taken !== e_tkn || cycles !== e_cyc) begin
            errors++;
            $display("FAIL %s: got vld=%0b npc=%04h tkn=%0b cyc=%0d expected vld=%0b npc=%04h tkn=%0b cyc=%0d",
                     tag, out_valid, npc, taken, cycles, e_vld, e_npc, e_tkn, e_cyc);
        end
    endtask

    task automatic run_op(input logic [3:0] a_op, input logic [15:0] a_pc, input logic [11:0] a_k,
                          input logic [7:0] a_sreg, input logic [2:0] a_fs, input logic [2:0] a_bi,
                          input logic [7:0] a_tb, input logic [7:0] a_rd, input logic [7:0] a_rr,
                          input logic [15:0] a_z, input logic a_two, input string extra);
        logic [15:0] e_npc;
        logic        e_tkn;
        logic [1:0]  e_cyc;
        string       tag;
        model(a_op, a_pc, a_k, a_sreg, a_fs, a_bi, a_tb, a_rd, a_rr, a_z, a_two,
              e_npc, e_tkn, e_cyc, tag);
        in_valid = 1'b1; op = a_op; pc = a_pc; offset = a_k; sreg = a_sreg;
        flag_sel = a_fs; bit_idx = a_bi; test_byte = a_tb; rd_val = a_rd;
        rr_val = a_rr; zptr = a_z; next_two_word = a_two;
        @(negedge clk);
        // R9: result visible one edge after acceptance
        check_out({tag, extra}, e_npc, e_tkn, e_cyc, 1'b1);
        last_npc = e_npc; last_tkn = e_tkn; last_cyc = e_cyc;
    endtask

    initial begin
        void'($urandom(32'h0bad5eed));
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        check_out("R1", 16'h0000, 1'b0, 2'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: still idle after release with no instruction
        check_out("R1 idle", 16'h0000, 1'b0, 2'd0, 1'b0);

        // R2 taken forward max offset (+63) on Z flag
        run_op(4'd1, 16'h0100, 12'h03F, 8'h02, 3'd1, 3'd0, 8'h00, 8'h0, 8'h0, 16'h0, 1'b0, " fwd");
        // R2 backward most negative (-64) with clear-test
        run_op(4'd2, 16'h0100, 12'hFC0, 8'h00, 3'd0, 3'd0, 8'h00, 8'h0, 8'h0, 16'h0, 1'b0, " back");
        // R3 not taken, upper offset bits ignored for short branch
        run_op(4'd1, 16'h0200, 12'hF85, 8'hFB, 3'd2, 3'd0, 8'h00, 8'h0, 8'h0, 16'h0, 1'b0, " untaken");
        // R4 N=1 V=1 S=0: greater-or-equal taken
        run_op(4'd3, 16'h0300, 12'h005, 8'h0C, 3'd0, 3'd0, 8'h00, 8'h0, 8'h0, 16'h0, 1'b0, " ge");
        // R4 N=1 V=0 S=0: less-than taken although S clear
        run_op(4'd4, 16'h0300, 12'h005, 8'h04, 3'd0, 3'd0, 8'h00, 8'h0, 8'h0, 16'h0, 1'b0, " lt");
        // R4 S=1 only: less-than not taken
        run_op(4'd4, 16'h0300, 12'h005, 8'h10, 3'd0, 3'd0, 8'h00, 8'h0, 8'h0, 16'h0, 1'b0, " s-ignored");
        // R5 relative jump backward, R11 wrap below zero
        run_op(4'd5, 16'h0002, 12'h800, 8'h00, 3'd0, 3'd0, 8'h00, 8'h0, 8'h0, 16'h0, 1'b0, " R11 wrap");
        // R5 relative call forward
        run_op(4'd6, 16'h1000, 12'h7FF, 8'h00, 3'd0, 3'd0, 8'h00, 8'h0, 8'h0, 16'h0, 1'b0, " call");
        // R6 indirect jump and call
        run_op(4'd7, 16'h1234, 12'h000, 8'h00, 3'd0, 3'd0, 8'h00, 8'h0, 8'h0, 16'hBEEF, 1'b0, " ijmp");
        run_op(4'd8, 16'h1234, 12'h000, 8'h00, 3'd0, 3'd0, 8'h00, 8'h0, 8'h0, 16'h0F0F, 1'b1, " icall");
        // R7 skip-if-clear over two-word instruction
        run_op(4'd9, 16'h0400, 12'h000, 8'h00, 3'd0, 3'd5, 8'hDF, 8'h0, 8'h0, 16'h0, 1'b1, " two-word");
        // R7 skip-if-set false while two-word flag set
        run_op(4'd10, 16'h0400, 12'h000, 8'h00, 3'd0, 3'd5, 8'hDF, 8'h0, 8'h0, 16'h0, 1'b1, " no-skip");
        // R8 equal, one-word skip
        run_op(4'd11, 16'h0500, 12'h000, 8'h00, 3'd0, 3'd0, 8'h00, 8'h5A, 8'h5A, 16'h0, 1'b0, " eq");
        // R8 unequal
        run_op(4'd11, 16'h0500, 12'h000, 8'h00, 3'd0, 3'd0, 8'h00, 8'h5A, 8'h5B, 16'h0, 1'b1, " ne");
        // R11 skip wraps at top of address space
        run_op(4'd10, 16'hFFFE, 12'h000, 8'h00, 3'd0, 3'd7, 8'h80, 8'h0, 8'h0, 16'h0, 1'b1, " R11");
        // R10 undefined opcodes
        run_op(4'd0, 16'hFFFF, 12'hFFF, 8'hFF, 3'd0, 3'd0, 8'hFF, 8'h1, 8'h1, 16'h0, 1'b1, " nop wrap R11");
        run_op(4'd13, 16'h0700, 12'h123, 8'hFF, 3'd0, 3'd0, 8'hFF, 8'h1, 8'h1, 16'h9999, 1'b1, " undefined");

        // R9 idle cycle holds previous outputs
        run_op(4'd6, 16'h2000, 12'h010, 8'h00, 3'd0, 3'd0, 8'h00, 8'h0, 8'h0, 16'h0, 1'b0, " pre-idle");
        in_valid = 1'b0; op = 4'd7; zptr = 16'h4444; pc = 16'h7777;
        @(negedge clk);
        check_out("R9 hold", last_npc, last_tkn, last_cyc, 1'b0);

        // random mix, conditions and length flag drawn independently
        for (int i = 0; i < 600; i++) begin
            logic [7:0] ra;
            ra = 8'($urandom);
            run_op(4'($urandom), 16'($urandom), 12'($urandom), 8'($urandom),
                   3'($urandom), 3'($urandom), 8'($urandom), ra,
                   ($urandom % 4 == 0) ? ra : 8'($urandom),
                   16'($urandom), 1'($urandom), " rnd");
            if ($urandom % 8 == 0) begin
                in_valid = 1'b0; op = 4'($urandom); pc = 16'($urandom);
                @(negedge clk);
                check_out("R9 rnd hold", last_npc, last_tkn, last_cyc, 1'b0);
            end
        end

        in_valid = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule